// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a memory-mapped countdown timer of the kind that sits inside a per-core interrupt controller. Software programs a local-vector word (an 8-bit vector, a mask bit and a one-shot/periodic select), an initial count, and a divide code that sets how many clocks make up one count step. Writing the initial count loads the live counter and starts (or restarts) the countdown. When the countdown expires, the block emits a one-cycle interrupt request that carries the programmed vector, unless the request is masked.

In periodic mode the counter reloads from the initial count on expiry and runs again. In one-shot mode it stops at zero and stays quiet until the initial count is written again. The live counter value can be read back at its own offset. Writes to that offset have no effect. Prioritising and accepting the request is left to the surrounding controller.

Top module: `cntdn_timer`

## Requirements
- R1: After reset the vector word reads 0x0001_0000 (mask set, one-shot, vector 0). The initial count, the current count and the divide code read 0, and `irq_pulse` is low.
- R2: The vector word at offset 0x320 holds the vector in bits 7:0, the mask in bit 16 and periodic mode in bit 17, and reads every other bit as 0. The divide register at 0x3E0 keeps only bits 3, 1 and 0 and reads the others as 0. The initial count at 0x380 reads back as written.
- R3: Writing a nonzero value N to offset 0x380 loads N into the current count (offset 0x390). The current count then falls by one at each divided step.
- R4: The divide code {bit3,bit1,bit0} selects clocks per step: 000=2, 001=4, 010=8, 011=16, 100=32, 101=64, 110=128, 111=1 (so 0xB gives 1).
- R5: In one-shot mode, an unmasked expiry raises `irq_pulse` N×D clock edges after the write edge. The current count is then 0, and no further pulse occurs.
- R6: In periodic mode (bit 17 = 1), unmasked pulses repeat every N×D clock edges, because the counter reloads N on expiry.
- R7: With the mask bit set, no pulse is emitted. Expiry still reloads the counter in periodic mode and stops it at 0 in one-shot mode.
- R8: Each pulse lasts one cycle when N×D > 1, and `irq_vector` carries the programmed vector in that cycle.
- R9: Writing 0 to the initial count stops the timer with the current count at 0, and no pulse follows. Writing a new count while the timer runs restarts the countdown from that count, with the step divider cleared.
- R10: A write to the current-count offset 0x390 does not change the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte offset for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector that goes with `irq_pulse` |

## Verification
The bound checker checks on every cycle the following properties. No pulse follows a cycle in which the mask was set. Every pulse is preceded by an expiry. A one-shot pulse finds the counter at zero. A running counter is never zero. Between loads and expiries the counter only holds or steps down by one. The bench scenarios cover the rest: the exact expiry cycle for each of the eight divide codes, the periodic spacing, the masked reload and stop, restart and stop on initial-count writes, the register field layout, and a write to the read-only count being ignored.

// File: rtl/cntdn_timer_pkg.sv
package cntdn_timer_pkg;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 32;
  localparam int DIV_CODE_W = 3;
  localparam int PRE_W      = (2 ** DIV_CODE_W) - 1;

  localparam logic [ADDR_W-1:0] OFF_VEC  = 12'h320;
  localparam logic [ADDR_W-1:0] OFF_INIT = 12'h380;
  localparam logic [ADDR_W-1:0] OFF_CUR  = 12'h390;
  localparam logic [ADDR_W-1:0] OFF_DIV  = 12'h3E0;

  localparam int BIT_MASK = 16;
  localparam int BIT_PER  = 17;

  typedef struct packed {
    logic       periodic;
    logic       mask;
    logic [7:0] vector;
  } vec_word_t;
endpackage

// File: rtl/cntdn_regs.sv
module cntdn_regs
  import cntdn_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [CNT_W-1:0]      cur_cnt,
  output logic [DATA_W-1:0]     rdata,
  output vec_word_t             vec_q,
  output logic [CNT_W-1:0]      init_q,
  output logic [DIV_CODE_W-1:0] code_q,
  output logic                  init_wr
);
  logic                  vec_we, div_we;
  vec_word_t             vec_d;
  logic [CNT_W-1:0]      init_d;
  logic [DIV_CODE_W-1:0] code_d;

  always_comb begin
    vec_we  = wr_en && (addr == OFF_VEC);
    div_we  = wr_en && (addr == OFF_DIV);
    init_wr = wr_en && (addr == OFF_INIT);
    vec_d   = vec_q;
    init_d  = init_q;
    code_d  = code_q;
    if (vec_we) begin
      vec_d.periodic = wdata[BIT_PER];
      vec_d.mask     = wdata[BIT_MASK];
      vec_d.vector   = wdata[7:0];
    end
    if (init_wr) init_d = wdata[CNT_W-1:0];
    if (div_we)  code_d = {wdata[3], wdata[1], wdata[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '{periodic: 1'b0, mask: 1'b1, vector: 8'h00};
      init_q <= '0;
      code_q <= '0;
    end else begin
      vec_q  <= vec_d;
      init_q <= init_d;
      code_q <= code_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFF_VEC: begin
        rdata[7:0]      = vec_q.vector;
        rdata[BIT_MASK] = vec_q.mask;
        rdata[BIT_PER]  = vec_q.periodic;
      end
      OFF_INIT: rdata[CNT_W-1:0] = init_q;
      OFF_CUR:  rdata[CNT_W-1:0] = cur_cnt;
      OFF_DIV:  begin
        rdata[3] = code_q[2];
        rdata[1] = code_q[1];
        rdata[0] = code_q[0];
      end
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/cntdn_prescale.sv
module cntdn_prescale
  import cntdn_timer_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  run,
  input  logic [DIV_CODE_W-1:0] code,
  output logic                  tick
);
  logic [PRE_W-1:0] pcnt_q, pcnt_d, limit;
  logic             at_limit;

  always_comb begin
    if (code == '1) limit = '0;
    else            limit = (PRE_W'(1) << (code + DIV_CODE_W'(1))) - PRE_W'(1);
    at_limit = (pcnt_q >= limit);
    tick     = run && at_limit;
    pcnt_d   = pcnt_q;
    if (clr)      pcnt_d = '0;
    else if (run) pcnt_d = at_limit ? '0 : pcnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/cntdn_counter.sv
module cntdn_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             periodic,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cur_q,
  output logic             running_q,
  output logic             expire
);
  logic [CNT_W-1:0] cur_d;
  logic             running_d;

  always_comb begin
    expire    = running_q && tick && (cur_q == CNT_W'(1));
    cur_d     = cur_q;
    running_d = running_q;
    if (load) begin
      cur_d     = load_val;
      running_d = (load_val != '0);
    end else if (expire) begin
      if (periodic) begin
        cur_d = reload_val;
      end else begin
        cur_d     = '0;
        running_d = 1'b0;
      end
    end else if (running_q && tick) begin
      cur_d = cur_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q     <= '0;
      running_q <= 1'b0;
    end else begin
      cur_q     <= cur_d;
      running_q <= running_d;
    end
  end
endmodule

// File: rtl/cntdn_timer.sv
module cntdn_timer
  import cntdn_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_pulse,
  output logic [7:0]        irq_vector
);
  vec_word_t             vec_q;
  logic [CNT_W-1:0]      init_q, cur_cnt;
  logic [DIV_CODE_W-1:0] code_q;
  logic                  init_wr, tick, running, expire;
  logic                  irq_d;
  logic [7:0]            vec_d;

  cntdn_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cur_cnt(cur_cnt), .rdata(rdata), .vec_q(vec_q), .init_q(init_q),
    .code_q(code_q), .init_wr(init_wr)
  );

  cntdn_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .clr(init_wr), .run(running),
    .code(code_q), .tick(tick)
  );

  cntdn_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(init_wr), .load_val(wdata[CNT_W-1:0]),
    .tick(tick), .periodic(vec_q.periodic), .reload_val(init_q),
    .cur_q(cur_cnt), .running_q(running), .expire(expire)
  );

  always_comb begin
    irq_d = expire && !vec_q.mask;
    vec_d = expire ? vec_q.vector : irq_vector;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pulse  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_pulse  <= irq_d;
      irq_vector <= vec_d;
    end
  end
endmodule

// File: rtl/cntdn_timer_chk.sv
module cntdn_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_pulse,
  input logic             mask,
  input logic             periodic,
  input logic [CNT_W-1:0] cur_cnt,
  input logic             running,
  input logic             expire,
  input logic             init_wr
);
  // R7: a pulse never follows a cycle in which the mask was set
  p_masked_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !$past(mask));

  // R8: every pulse comes from an expiry on the previous edge
  p_pulse_from_expiry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(expire));

  // R5: a one-shot expiry leaves the counter at zero and stopped
  p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && !$past(periodic) && !$past(init_wr)) |-> (cur_cnt == '0 && !running));

  // R9: a running counter never shows zero
  p_running_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cur_cnt != '0));

  // R3: without a load or an expiry the count holds or steps down by one
  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(init_wr) && !$past(expire)) |->
      (cur_cnt == $past(cur_cnt) || cur_cnt == $past(cur_cnt) - CNT_W'(1)));
endmodule

bind cntdn_timer cntdn_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .mask(vec_q.mask),
  .periodic(vec_q.periodic), .cur_cnt(cur_cnt), .running(running),
  .expire(expire), .init_wr(init_wr)
);

// File: tb/tb_cntdn_timer.sv
module tb_cntdn_timer;
  logic        clk, rst_n, wr_en;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  cntdn_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // {divide register value, count N, expected edges N*D}
  localparam logic [39:0] TABLE [8] = '{
    {8'h0B, 16'd5, 16'd5},
    {8'h00, 16'd3, 16'd6},
    {8'h01, 16'd2, 16'd8},
    {8'h02, 16'd2, 16'd16},
    {8'h03, 16'd1, 16'd16},
    {8'h08, 16'd1, 16'd32},
    {8'h09, 16'd1, 16'd64},
    {8'h0A, 16'd1, 16'd128}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  // count edges from the last write edge until a pulse, up to limit
  task automatic wait_irq(input int limit, output int k);
    k = 0;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); #2;
      if (irq_pulse) begin k = i; break; end
    end
  endtask

  task automatic quiet(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      if (irq_pulse) seen++;
    end
  endtask

  initial begin
    #1000000;
    n_errors++; n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int k, s;
    wr_en = 0; addr = 0; wdata = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #3;
    // R1 reset state
    rd(12'h320, d); check(d == 32'h0001_0000, "R1 vec word", d, 32'h0001_0000);
    rd(12'h380, d); check(d == 0, "R1 init", d, 0);
    rd(12'h390, d); check(d == 0, "R1 cur", d, 0);
    rd(12'h3E0, d); check(d == 0, "R1 div", d, 0);
    check(irq_pulse == 0, "R1 irq", irq_pulse, 0);

    // R2 field layout
    wr(12'h320, 32'hFFFF_FFFF); rd(12'h320, d);
    check(d == 32'h0003_00FF, "R2 vec all ones", d, 32'h0003_00FF);
    wr(12'h3E0, 32'hFFFF_FFFF); rd(12'h3E0, d);
    check(d == 32'h0000_000B, "R2 div all ones", d, 32'hB);

    // R4/R5/R8 table walk: one-shot, unmasked, vector 0x5A
    wr(12'h320, 32'h0000_005A);
    for (int t = 0; t < 8; t++) begin
      wr(12'h3E0, {24'h0, TABLE[t][39:32]});
      wr(12'h380, {16'h0, TABLE[t][31:16]});
      wait_irq(400, k);
      check(k == int'(TABLE[t][15:0]), "R4 expiry edge", k, TABLE[t][15:0]);
      check(irq_vector == 8'h5A, "R8 vector", irq_vector, 8'h5A);
      @(posedge clk); #2;
      check(irq_pulse == 0, "R8 single cycle", irq_pulse, 0);
      rd(12'h390, d); check(d == 0, "R5 stays zero", d, 0);
      quiet(300, s); check(s == 0, "R5 no repeat", s, 0);
    end

    // R3 decrement with divide-by-1
    wr(12'h3E0, 32'hB);
    wr(12'h380, 32'd10);
    repeat (3) @(posedge clk); #2;
    rd(12'h390, d); check(d == 7, "R3 live count", d, 7);
    // R10 write to current count ignored
    wr(12'h390, 32'd1000); rd(12'h390, d);
    check(d == 6, "R10 cur write ignored", d, 6);
    // R9 stop by zero write
    wr(12'h380, 32'd0); rd(12'h390, d);
    check(d == 0, "R9 stop clears", d, 0);
    quiet(20, s); check(s == 0, "R9 no pulse after stop", s, 0);
    // R9 restart with a shorter count, divide by 4
    wr(12'h3E0, 32'h1);
    wr(12'h380, 32'd50);
    repeat (9) @(posedge clk);
    wr(12'h380, 32'd3);
    wait_irq(400, k); check(k == 12, "R9 restart", k, 12);

    // R6 periodic spacing, vector 0x41
    wr(12'h3E0, 32'hB);
    wr(12'h320, 32'h0002_0041);
    wr(12'h380, 32'd4);
    wait_irq(50, k); check(k == 4, "R6 first period", k, 4);
    check(irq_vector == 8'h41, "R8 periodic vector", irq_vector, 8'h41);
    wait_irq(50, k); check(k == 4, "R6 second period", k, 4);
    wait_irq(50, k); check(k == 4, "R6 third period", k, 4);

    // R7 masked periodic still reloads
    wr(12'h320, 32'h0003_0041);
    wr(12'h380, 32'd4);
    quiet(12, s); check(s == 0, "R7 masked periodic silent", s, 0);
    rd(12'h390, d); check(d == 4, "R7 reload while masked", d, 4);
    // R7 masked one-shot stops
    wr(12'h320, 32'h0001_0041);
    wr(12'h380, 32'd4);
    quiet(10, s); check(s == 0, "R7 masked oneshot silent", s, 0);
    rd(12'h390, d); check(d == 0, "R7 masked oneshot stops", d, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule